// File: doc/BRIEF.md
# PCI Target Data-Phase Termination Controller

This block sits in the target side of a PCI-to-internal-bus bridge. It chooses how each PCI data phase ends. The choices are normal completion, retry, disconnect with data, disconnect without data, or target abort. The logic that watches the bus presents one data phase per `phase_vld` pulse. The phase arrives with its direction, a flag for the Memory Read command, a first-phase flag, a "master wants more" flag, the address and the active-low byte enables. The backend supplies level status: read data fetched, posted-write FIFO drained, next FIFO slot available, and a fetch error flag.

Reads are delayed. The first attempt starts a backend fetch and is answered with retry. The address and command of the fetch are remembered. Only a later attempt with the same address and command can collect the data, and every other access is retried meanwhile. An optional timer drops a delayed read that is not attempted again within 2^TMO_W cycles. Burst writes stop with disconnect without data when the byte enables change. Byte enables are reduced to an access size, or to a no-op for an all-disabled write.

The result appears for exactly one cycle on `term_vld`, one clock after the phase. It comes with `term_code`, `acc_size`, `acc_nop` and a `fetch_start` pulse that tells the backend to begin a read fetch.

Top module: `pci_term_ctrl`

## Requirements
- R1: A read phase (`first_phase`=1) arriving while no delayed read is pending gives `term_code`=1 (retry) together with `fetch_start`=1. A repeat of that read while `rd_ready`=0 gives retry with `fetch_start`=0. No read returns data before the fetch starts.
- R2: A read whose address and Memory Read flag both equal the pending read, and which arrives with `rd_ready`=1 and `more_req`=0, gives `term_code`=0 (normal). It also frees the tracker, so the next new read starts a fresh fetch. Continuation phases of an accepted read burst (`first_phase`=0) end normally while the FIFO keeps up.
- R3: While a delayed read is pending, any access that does not match it (another address, another command, or a write) gives retry and does not assert `fetch_start`.
- R4: A first write phase with no read pending and `wfifo_empty`=0 gives retry.
- R5: `term_code`=2 (disconnect with data) is given when a data-delivering phase has `more_req`=1 and `next_avail`=0. It is also given for a read using the Memory Read command (`cmd_memrd`=1) that delivers data with `more_req`=1.
- R6: In a burst write, a continuation phase whose `cbe_n` differs from the first phase's `cbe_n` gives `term_code`=3 (disconnect without data).
- R7: A matching or continuing read phase with `be_err`=1 gives `term_code`=4 (target abort), even when `rd_ready`=1. `be_err` has no effect on write phases.
- R8: `acc_size` is 0 (8-bit) for `cbe_n` 1110, 1101, 1011 and 0111. It is 1 (16-bit) for 1100 and 0011. It is 2 (32-bit) for 0000 and for every other pattern.
- R9: A write with `cbe_n`=1111 gives `acc_nop`=1. A read with `cbe_n`=1111 gives `acc_nop`=0 and `acc_size`=2.
- R10: With `discard_en`=1, a pending read is dropped after 2^TMO_W cycles without a matching attempt, and each matching retry restarts the count. With `discard_en`=0 the read stays pending.
- R11: Every `phase_vld` cycle is followed one clock later by `term_vld`=1 for exactly one cycle. `term_vld` is 0 in every other cycle, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_vld | input | 1 | One data phase presented this cycle |
| is_read | input | 1 | 1 = read phase, 0 = write phase |
| cmd_memrd | input | 1 | Phase uses the Memory Read command |
| first_phase | input | 1 | First data phase of a transaction |
| more_req | input | 1 | Master wants further data phases |
| addr | input | AW | Access address |
| cbe_n | input | 4 | Active-low byte enables |
| rd_ready | input | 1 | Backend holds the fetched read data |
| wfifo_empty | input | 1 | Posted-write FIFO fully drained |
| next_avail | input | 1 | Next FIFO slot is available |
| be_err | input | 1 | Backend reported an error on the fetch |
| discard_en | input | 1 | Enable discard of unretried reads |
| term_vld | output | 1 | Termination result valid (one cycle) |
| term_code | output | 3 | 0 normal, 1 retry, 2 disconnect with data, 3 disconnect without data, 4 target abort |
| acc_size | output | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| acc_nop | output | 1 | Write performs no store |
| fetch_start | output | 1 | Pulse: backend starts a read fetch |

## Verification
The assertions check four properties on every cycle. Each phase produces exactly one result strobe a cycle later, and a fetch start only ever comes with a retry. Target abort only answers a read that saw a fetch error. Disconnect without data and the no-op flag only answer writes. The bench scenarios are needed for the rest. They cover which retried attempt matches the pending read, the priority of abort over data delivery, and byte-enable change detection across a burst. They also cover the discard timer's restart and expiry, which only shows after tens of thousands of idle cycles.

// File: rtl/pci_term_pkg.sv
package pci_term_pkg;
  typedef enum logic [2:0] {
    TC_NORMAL      = 3'd0,
    TC_RETRY       = 3'd1,
    TC_DISC_DATA   = 3'd2,
    TC_DISC_NODATA = 3'd3,
    TC_ABORT       = 3'd4
  } term_e;

  typedef enum logic [1:0] {
    AS_BYTE = 2'd0,
    AS_HALF = 2'd1,
    AS_WORD = 2'd2
  } asize_e;
endpackage

// File: rtl/pci_cbe_norm.sv
module pci_cbe_norm
  import pci_term_pkg::*;
(
  input  logic [3:0] cbe_n_i,
  input  logic       is_read_i,
  output asize_e     size_o,
  output logic       nop_o
);
  always_comb begin
    size_o = AS_WORD;
    nop_o  = 1'b0;
    case (cbe_n_i)
      4'b1110, 4'b1101, 4'b1011, 4'b0111: size_o = AS_BYTE;
      4'b1100, 4'b0011:                   size_o = AS_HALF;
      4'b1111:                            nop_o  = !is_read_i;
      default:                            size_o = AS_WORD;
    endcase
  end
endmodule

// File: rtl/pci_dread_trk.sv
module pci_dread_trk #(
  parameter int AW    = 32,
  parameter int TMO_W = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          touch_i,
  input  logic          done_i,
  input  logic          discard_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic          mr_i,
  output logic          pend_o,
  output logic          match_o
);
  localparam logic [TMO_W-1:0] CNT_MAX = '1;

  logic              pend_q, pend_d;
  logic [AW-1:0]     addr_q;
  logic              mr_q;
  logic [TMO_W-1:0]  cnt_q, cnt_d;
  logic              expire;

  always_comb begin
    expire = pend_q && discard_en_i && (cnt_q == CNT_MAX) && !touch_i && !done_i;
    pend_d = pend_q;
    if (start_i)               pend_d = 1'b1;
    else if (done_i || expire) pend_d = 1'b0;
    cnt_d = cnt_q;
    if (start_i || touch_i || done_i)  cnt_d = '0;
    else if (pend_q && discard_en_i)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      mr_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      if (start_i) begin
        addr_q <= addr_i;
        mr_q   <= mr_i;
      end
    end
  end

  assign pend_o  = pend_q;
  assign match_o = pend_q && (addr_q == addr_i) && (mr_q == mr_i);
endmodule

// File: rtl/pci_wbe_trk.sv
module pci_wbe_trk #(
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic [BW-1:0] cbe_n_i,
  output logic          diff_o
);
  logic [BW-1:0] be_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     be_q <= '0;
    else if (cap_i) be_q <= cbe_n_i;
  end

  assign diff_o = (be_q != cbe_n_i);
endmodule

// File: rtl/pci_term_ctrl.sv
module pci_term_ctrl
  import pci_term_pkg::*;
#(
  parameter int AW    = 32,
  parameter int TMO_W = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase_vld,
  input  logic          is_read,
  input  logic          cmd_memrd,
  input  logic          first_phase,
  input  logic          more_req,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    cbe_n,
  input  logic          rd_ready,
  input  logic          wfifo_empty,
  input  logic          next_avail,
  input  logic          be_err,
  input  logic          discard_en,
  output logic          term_vld,
  output logic [2:0]    term_code,
  output logic [1:0]    acc_size,
  output logic          acc_nop,
  output logic          fetch_start
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  asize_e sz_c;
  logic   nop_c;
  logic   pend, match, wbe_diff;
  logic   trk_start, trk_touch, trk_done, wbe_cap;
  logic   rb_q, rb_d, wb_q, wb_d;
  term_e  code_d;
  logic   fetch_d;

  pci_cbe_norm u_norm (
    .cbe_n_i   (cbe_n),
    .is_read_i (is_read),
    .size_o    (sz_c),
    .nop_o     (nop_c)
  );

  pci_dread_trk #(.AW(AW), .TMO_W(TMO_W)) u_dread (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_i      (trk_start),
    .touch_i      (trk_touch),
    .done_i       (trk_done),
    .discard_en_i (discard_en),
    .addr_i       (addr),
    .mr_i         (cmd_memrd),
    .pend_o       (pend),
    .match_o      (match)
  );

  pci_wbe_trk #(.BW(4)) u_wbe (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cap_i   (wbe_cap),
    .cbe_n_i (cbe_n),
    .diff_o  (wbe_diff)
  );

  always_comb begin
    code_d    = TC_NORMAL;
    fetch_d   = 1'b0;
    trk_start = 1'b0;
    trk_touch = 1'b0;
    trk_done  = 1'b0;
    wbe_cap   = 1'b0;
    rb_d      = rb_q;
    wb_d      = wb_q;
    if (phase_vld) begin
      if (first_phase) begin
        rb_d = 1'b0;
        wb_d = 1'b0;
      end
      if (is_read) begin
        if (!first_phase && rb_q) begin
          if (be_err)                      begin code_d = TC_ABORT;     rb_d = 1'b0; end
          else if (!more_req)              begin code_d = TC_NORMAL;    rb_d = 1'b0; end
          else if (cmd_memrd || !next_avail) begin code_d = TC_DISC_DATA; rb_d = 1'b0; end
          else                             code_d = TC_NORMAL;
        end else if (!pend) begin
          code_d    = TC_RETRY;
          fetch_d   = 1'b1;
          trk_start = 1'b1;
        end else if (!match) begin
          code_d = TC_RETRY;
        end else if (be_err) begin
          code_d   = TC_ABORT;
          trk_done = 1'b1;
        end else if (!rd_ready) begin
          code_d    = TC_RETRY;
          trk_touch = 1'b1;
        end else begin
          trk_done = 1'b1;
          if (more_req && (cmd_memrd || !next_avail)) code_d = TC_DISC_DATA;
          else begin
            code_d = TC_NORMAL;
            rb_d   = more_req;
          end
        end
      end else begin
        if (!first_phase && wb_q) begin
          if (wbe_diff)                     begin code_d = TC_DISC_NODATA; wb_d = 1'b0; end
          else if (more_req && !next_avail) begin code_d = TC_DISC_DATA;   wb_d = 1'b0; end
          else if (!more_req)               begin code_d = TC_NORMAL;      wb_d = 1'b0; end
          else                              code_d = TC_NORMAL;
        end else if (pend || !wfifo_empty) begin
          code_d = TC_RETRY;
        end else begin
          wbe_cap = 1'b1;
          if (more_req && !next_avail) code_d = TC_DISC_DATA;
          else begin
            code_d = TC_NORMAL;
            wb_d   = more_req;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      term_vld    <= 1'b0;
      term_code   <= TC_NORMAL;
      acc_size    <= AS_WORD;
      acc_nop     <= 1'b0;
      fetch_start <= 1'b0;
      rb_q        <= 1'b0;
      wb_q        <= 1'b0;
    end else begin
      term_vld    <= phase_vld;
      fetch_start <= fetch_d;
      rb_q        <= rb_d;
      wb_q        <= wb_d;
      if (phase_vld) begin
        term_code <= code_d;
        acc_size  <= sz_c;
        acc_nop   <= nop_c;
      end
    end
  end
endmodule

// File: rtl/pci_term_chk.sv
module pci_term_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          phase_vld,
  input logic          is_read,
  input logic          cmd_memrd,
  input logic          first_phase,
  input logic          more_req,
  input logic [AW-1:0] addr,
  input logic [3:0]    cbe_n,
  input logic          rd_ready,
  input logic          wfifo_empty,
  input logic          next_avail,
  input logic          be_err,
  input logic          discard_en,
  input logic          term_vld,
  input logic [2:0]    term_code,
  input logic [1:0]    acc_size,
  input logic          acc_nop,
  input logic          fetch_start
);
  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) phase_vld |=> term_vld); // R11
  AST_STROBE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) !phase_vld |=> !term_vld); // R11
  AST_FETCH_WITH_RETRY: assert property (@(posedge clk) disable iff (!rst_n) fetch_start |-> (term_vld && term_code == 3'd1)); // R1
  AST_ABORT_ON_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n) (term_vld && term_code == 3'd4) |-> ($past(is_read) && $past(be_err))); // R7
  AST_NODATA_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (term_vld && term_code == 3'd3) |-> !$past(is_read)); // R6
  AST_NOP_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (term_vld && acc_nop) |-> (!$past(is_read) && $past(cbe_n) == 4'hF)); // R9
endmodule

bind pci_term_ctrl pci_term_chk #(.AW(AW)) chk_i (.*);

// File: tb/pci_term_ctrl_tb_top.sv
module pci_term_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_vld = 1'b0, is_read = 1'b0, cmd_memrd = 1'b0;
  logic        first_phase = 1'b1, more_req = 1'b0;
  logic [31:0] addr = '0;
  logic [3:0]  cbe_n = '0;
  logic        rd_ready = 1'b0, wfifo_empty = 1'b1, next_avail = 1'b1;
  logic        be_err = 1'b0, discard_en = 1'b0;
  logic        term_vld, acc_nop, fetch_start;
  logic [2:0]  term_code;
  logic [1:0]  acc_size;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pci_term_ctrl dut_i (.*);

  // entry: [6:3] cbe_n, [2:1] expected size, [0] expected nop (all writes)
  localparam logic [6:0] VEC [10] = '{
    {4'b0000, 2'd2, 1'b0}, {4'b1110, 2'd0, 1'b0}, {4'b1101, 2'd0, 1'b0},
    {4'b1011, 2'd0, 1'b0}, {4'b0111, 2'd0, 1'b0}, {4'b1100, 2'd1, 1'b0},
    {4'b0011, 2'd1, 1'b0}, {4'b1010, 2'd2, 1'b0}, {4'b0110, 2'd2, 1'b0},
    {4'b1111, 2'd2, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic phase(input logic rd, input logic mr, input logic fst,
                       input logic more, input logic [31:0] a, input logic [3:0] be);
    @(negedge clk);
    phase_vld = 1'b1; is_read = rd; cmd_memrd = mr; first_phase = fst;
    more_req = more; addr = a; cbe_n = be;
    @(negedge clk);
    phase_vld = 1'b0;
  endtask

  task automatic expect_term(input string tag, input int code, input int fetch);
    check({tag, " strobe"}, term_vld, 1);
    check({tag, " code"}, term_code, code);
    check({tag, " fetch"}, fetch_start, fetch);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset term_vld", term_vld, 0);
    check("R11 reset fetch_start", fetch_start, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 / R9 byte enable table
    for (int i = 0; i < 10; i++) begin
      phase(1'b0, 1'b0, 1'b1, 1'b0, 32'h100, VEC[i][6:3]);
      check("R8 size", acc_size, VEC[i][2:1]);
      check("R9 nop", acc_nop, VEC[i][0]);
      check("R8 write code", term_code, 0);
    end
    @(negedge clk);
    check("R11 one-cycle strobe", term_vld, 0);

    // R1 delayed read, R9 read with 1111
    phase(1'b1, 1'b0, 1'b1, 1'b0, 32'hA0, 4'b1111);
    expect_term("R1 new read", 1, 1);
    check("R9 read nop", acc_nop, 0);
    check("R9 read size", acc_size, 2);
    phase(1'b1, 1'b0, 1'b1, 1'b0, 32'hA0, 4'b0000);
    expect_term("R1 repeat not ready", 1, 0);
    // R3 mismatches
    phase(1'b1, 1'b0, 1'b1, 1'b0, 32'hB0, 4'b0000);
    expect_term("R3 other addr", 1, 0);
    phase(1'b1, 1'b1, 1'b1, 1'b0, 32'hA0, 4'b0000);
    expect_term("R3 other cmd", 1, 0);
    phase(1'b0, 1'b0, 1'b1, 1'b0, 32'hA0, 4'b0000);
    expect_term("R3 write while pending", 1, 0);
    // R2 completion
    rd_ready = 1'b1;
    phase(1'b1, 1'b0, 1'b1, 1'b0, 32'hA0, 4'b0000);
    expect_term("R2 data delivered", 0, 0);
    rd_ready = 1'b0;
    phase(1'b1, 1'b0, 1'b1, 1'b0, 32'hB0, 4'b0000);
    expect_term("R2 tracker freed", 1, 1);

    // R7 abort beats data; write error ignored
    rd_ready = 1'b1; be_err = 1'b1;
    phase(1'b1, 1'b0, 1'b1, 1'b0, 32'hB0, 4'b0000);
    expect_term("R7 abort", 4, 0);
    phase(1'b0, 1'b0, 1'b1, 1'b0, 32'hC0, 4'b0000);
    expect_term("R7 write error ignored", 0, 0);
    be_err = 1'b0; rd_ready = 1'b0;

    // R4 write FIFO still draining
    wfifo_empty = 1'b0;
    phase(1'b0, 1'b0, 1'b1, 1'b0, 32'hC0, 4'b0000);
    expect_term("R4 write retry", 1, 0);
    wfifo_empty = 1'b1;

    // R5 disconnect with data
    phase(1'b1, 1'b0, 1'b1, 1'b1, 32'hD0, 4'b0000);
    expect_term("R5 read retry", 1, 1);
    rd_ready = 1'b1; next_avail = 1'b0;
    phase(1'b1, 1'b0, 1'b1, 1'b1, 32'hD0, 4'b0000);
    expect_term("R5 next not avail", 2, 0);
    rd_ready = 1'b0; next_avail = 1'b1;
    phase(1'b1, 1'b1, 1'b1, 1'b1, 32'hD4, 4'b0000);
    expect_term("R5 memrd retry", 1, 1);
    rd_ready = 1'b1;
    phase(1'b1, 1'b1, 1'b1, 1'b1, 32'hD4, 4'b0000);
    expect_term("R5 memrd burst", 2, 0);
    rd_ready = 1'b0;
    // R2 read burst continuation
    phase(1'b1, 1'b0, 1'b1, 1'b1, 32'hE0, 4'b0000);
    expect_term("R2 burst retry", 1, 1);
    rd_ready = 1'b1;
    phase(1'b1, 1'b0, 1'b1, 1'b1, 32'hE0, 4'b0000);
    expect_term("R2 burst first", 0, 0);
    phase(1'b1, 1'b0, 1'b0, 1'b1, 32'hE4, 4'b0000);
    expect_term("R2 burst middle", 0, 0);
    phase(1'b1, 1'b0, 1'b0, 1'b0, 32'hE8, 4'b0000);
    expect_term("R2 burst last", 0, 0);
    rd_ready = 1'b0;

    // R6 byte enable change in burst write
    phase(1'b0, 1'b0, 1'b1, 1'b1, 32'h200, 4'b0000);
    expect_term("R6 burst first", 0, 0);
    phase(1'b0, 1'b0, 1'b0, 1'b1, 32'h204, 4'b0000);
    expect_term("R6 same be", 0, 0);
    phase(1'b0, 1'b0, 1'b0, 1'b1, 32'h208, 4'b1100);
    expect_term("R6 be changed", 3, 0);
    phase(1'b0, 1'b0, 1'b1, 1'b1, 32'h300, 4'b0000);
    next_avail = 1'b0;
    phase(1'b0, 1'b0, 1'b0, 1'b1, 32'h304, 4'b0000);
    expect_term("R5 write next not avail", 2, 0);
    next_avail = 1'b1;

    // R10 discard disabled: read stays pending
    discard_en = 1'b0;
    phase(1'b1, 1'b0, 1'b1, 1'b0, 32'hF0, 4'b0000);
    expect_term("R10 start F", 1, 1);
    repeat (33000) @(negedge clk);
    phase(1'b1, 1'b0, 1'b1, 1'b0, 32'hF8, 4'b0000);
    expect_term("R10 disabled keeps pending", 1, 0);
    rd_ready = 1'b1;
    phase(1'b1, 1'b0, 1'b1, 1'b0, 32'hF0, 4'b0000);
    expect_term("R10 complete F", 0, 0);
    rd_ready = 1'b0;

    // R10 discard enabled: restart then expiry
    discard_en = 1'b1;
    phase(1'b1, 1'b0, 1'b1, 1'b0, 32'h400, 4'b0000);
    expect_term("R10 start H", 1, 1);
    repeat (32000) @(negedge clk);
    phase(1'b1, 1'b0, 1'b1, 1'b0, 32'h400, 4'b0000);
    expect_term("R10 retry within window", 1, 0);
    repeat (32000) @(negedge clk);
    phase(1'b1, 1'b0, 1'b1, 1'b0, 32'h404, 4'b0000);
    expect_term("R10 restarted still pending", 1, 0);
    repeat (33000) @(negedge clk);
    phase(1'b1, 1'b0, 1'b1, 1'b0, 32'h404, 4'b0000);
    expect_term("R10 expired new fetch", 1, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule